// File: doc/BRIEF.md
# Segment Display Serial Command and RAM Controller

This block terminates a four-wire synchronous serial link (active-low select, serial clock, serial data and a command/data qualifier) and keeps the state that a multiplexed segment display is driven from. Eight bits shifted in most significant bit first make one word. The level of the qualifier at the eighth clock edge of each word sorts it into display data or a command.

A display data byte fills two neighbouring nibbles of an 18-entry by 4-bit display store. Commands load the address pointer, write one nibble, choose between forced-lit, forced-dark and normal display, or return the controller to its idle state. The pointer steps by two after a data byte and by one after a nibble write, and it wraps from 17 back to 0. The drive logic reads any entry combinationally and sees the current display mode. The serial pins are asynchronous to the system clock and pass through synchronizers before use.

Top module: `segram_ctrl`

## Requirements
- R1: While `ser_csn` is low, each rising edge of `ser_clk` shifts in one bit of `ser_dat`, most significant bit first. Every eight such edges complete one word.
- R2: A high level on `ser_csn` restarts the bit count. The bits of an unfinished word are discarded, and the next word starts cleanly after `ser_csn` falls again.
- R3: Only the level of `ser_cd` at the eighth clock edge of a word counts. Low marks a display data byte and high marks a command. Its level at the other seven edges has no effect.
- R4: Command `000AAAAA` loads the pointer with AAAAA modulo 18, so values 18 to 31 map onto 0 to 13.
- R5: A display data byte writes bits 7:4 to the entry at the pointer and bits 3:0 to the next entry (17 wraps to 0). The pointer then advances by 2 modulo 18.
- R6: Command `100xDDDD` writes DDDD to the entry at the pointer. The pointer then advances by 1 modulo 18.
- R7: Commands `001xxxxx`, `010xxxxx` and `011xxxxx` set `disp_mode` to 2 (all lit), 0 (all dark) and 1 (from RAM) respectively. They leave the RAM and the pointer unchanged.
- R8: Command `11x0xxxx` sets `disp_mode` to 0 and the pointer to 0, and leaves the RAM unchanged. Commands `101xxxxx` and `11x1xxxx` change nothing.
- R9: After `rst`, `disp_mode` is 0, the pointer is 0 and all 18 entries read 0.
- R10: `rd_nib` shows the entry selected by `rd_addr` in the same cycle, and reads 0 for `rd_addr` of 18 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_csn | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_cd | input | 1 | Command (1) or display data (0), taken at the 8th edge |
| rd_addr | input | 5 | Read index for the display store |
| rd_nib | output | 4 | Nibble stored at `rd_addr` |
| disp_mode | output | 2 | 0 dark, 1 from RAM, 2 all lit |

## Verification
The bench aims at the pointer wrap. It writes a data byte at entry 17 and a nibble at entry 17, and it issues out-of-range pointer loads. A design that got the wrap wrong would write outside the store or leave entry 0 unwritten. The bench also toggles the qualifier on the first seven bits and drops select in the middle of a word. A receiver that sampled the qualifier early, or kept stale bits, would misfile or shift the following words. The bench sends a reset command after filling the RAM, and sends the undefined opcodes. Either would expose a design that cleared the store, or that acted on a code it should ignore.

// File: rtl/segram_pkg.sv
package segram_pkg;

    localparam int SEG_N  = 18;
    localparam int NIB_W  = 4;
    localparam int WORD_W = 8;
    localparam int AW     = $clog2(SEG_N);
    localparam int CNT_W  = $clog2(WORD_W);

    typedef enum logic [1:0] {
        DISP_DARK = 2'd0,
        DISP_RAM  = 2'd1,
        DISP_LIT  = 2'd2
    } disp_mode_e;

    typedef struct packed {
        logic              is_cmd;
        logic [WORD_W-1:0] bits;
    } rx_word_t;

    typedef struct packed {
        logic             en;
        logic [AW-1:0]    addr;
        logic [NIB_W-1:0] nib;
    } nib_wr_t;

    function automatic logic [AW-1:0] step_one(input logic [AW-1:0] a);
        return (int'(a) >= SEG_N - 1) ? '0 : a + AW'(1);
    endfunction

    function automatic logic [AW-1:0] fold_addr(input logic [AW-1:0] a);
        return AW'(int'(a) % SEG_N);
    endfunction

endpackage

// File: rtl/segram_rx.sv
module segram_rx
    import segram_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     ser_csn,
    input  logic     ser_clk,
    input  logic     ser_dat,
    input  logic     ser_cd,
    output logic     word_vld,
    output rx_word_t word
);

    logic [SYNC_STAGES-1:0] s_clk, s_csn, s_dat, s_cd;
    logic                   clk_prev;
    logic [CNT_W-1:0]       bit_cnt;
    logic [WORD_W-2:0]      shreg;
    logic                   rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_clk <= '0;
            s_csn <= '1;
            s_dat <= '0;
            s_cd  <= '0;
            clk_prev <= 1'b0;
        end else begin
            s_clk <= {s_clk[SYNC_STAGES-2:0], ser_clk};
            s_csn <= {s_csn[SYNC_STAGES-2:0], ser_csn};
            s_dat <= {s_dat[SYNC_STAGES-2:0], ser_dat};
            s_cd  <= {s_cd[SYNC_STAGES-2:0], ser_cd};
            clk_prev <= s_clk[SYNC_STAGES-1];
        end
    end

    assign rise = s_clk[SYNC_STAGES-1] & ~clk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            word_vld <= 1'b0;
            word     <= '0;
        end else begin
            word_vld <= 1'b0;
            if (s_csn[SYNC_STAGES-1]) begin
                bit_cnt <= '0;
            end else if (rise) begin
                shreg <= {shreg[WORD_W-3:0], s_dat[SYNC_STAGES-1]};
                if (int'(bit_cnt) == WORD_W - 1) begin
                    bit_cnt     <= '0;
                    word_vld    <= 1'b1;
                    word.is_cmd <= s_cd[SYNC_STAGES-1];
                    word.bits   <= {shreg, s_dat[SYNC_STAGES-1]};
                end else begin
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/segram_cmd.sv
module segram_cmd
    import segram_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          word_vld,
    input  rx_word_t      word,
    output nib_wr_t       wr_a,
    output nib_wr_t       wr_b,
    output logic [AW-1:0] cur_addr,
    output disp_mode_e    mode
);

    logic [2:0] opc;
    assign opc = word.bits[WORD_W-1:WORD_W-3];

    always_comb begin
        wr_a = '0;
        wr_b = '0;
        if (word_vld) begin
            if (!word.is_cmd) begin
                wr_a.en   = 1'b1;
                wr_a.addr = cur_addr;
                wr_a.nib  = word.bits[2*NIB_W-1:NIB_W];
                wr_b.en   = 1'b1;
                wr_b.addr = step_one(cur_addr);
                wr_b.nib  = word.bits[NIB_W-1:0];
            end else if (opc == 3'b100) begin
                wr_a.en   = 1'b1;
                wr_a.addr = cur_addr;
                wr_a.nib  = word.bits[NIB_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            mode     <= DISP_DARK;
        end else if (word_vld) begin
            if (!word.is_cmd) begin
                cur_addr <= step_one(step_one(cur_addr));
            end else begin
                case (opc)
                    3'b000: cur_addr <= fold_addr(word.bits[AW-1:0]);
                    3'b001: mode <= DISP_LIT;
                    3'b010: mode <= DISP_DARK;
                    3'b011: mode <= DISP_RAM;
                    3'b100: cur_addr <= step_one(cur_addr);
                    3'b110, 3'b111: begin
                        if (!word.bits[4]) begin
                            mode     <= DISP_DARK;
                            cur_addr <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/segram_store.sv
module segram_store
    import segram_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  nib_wr_t          wr_a,
    input  nib_wr_t          wr_b,
    input  logic [AW-1:0]    rd_addr,
    output logic [NIB_W-1:0] rd_nib
);

    logic [NIB_W-1:0] cells [SEG_N];

    for (genvar i = 0; i < SEG_N; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                cells[i] <= '0;
            else if (wr_b.en && int'(wr_b.addr) == i)
                cells[i] <= wr_b.nib;
            else if (wr_a.en && int'(wr_a.addr) == i)
                cells[i] <= wr_a.nib;
        end
    end

    always_comb begin
        rd_nib = '0;
        for (int i = 0; i < SEG_N; i++)
            if (int'(rd_addr) == i) rd_nib = cells[i];
    end

endmodule

// File: rtl/segram_ctrl.sv
module segram_ctrl
    import segram_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_csn,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_cd,
    input  logic [AW-1:0]    rd_addr,
    output logic [NIB_W-1:0] rd_nib,
    output logic [1:0]       disp_mode
);

    logic          word_vld;
    rx_word_t      word;
    nib_wr_t       wr_a, wr_b;
    logic [AW-1:0] cur_addr;
    disp_mode_e    mode;

    segram_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst(rst), .ser_csn(ser_csn), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .ser_cd(ser_cd), .word_vld(word_vld), .word(word)
    );

    segram_cmd u_cmd (
        .clk(clk), .rst(rst), .word_vld(word_vld), .word(word),
        .wr_a(wr_a), .wr_b(wr_b), .cur_addr(cur_addr), .mode(mode)
    );

    segram_store u_store (
        .clk(clk), .rst(rst), .wr_a(wr_a), .wr_b(wr_b),
        .rd_addr(rd_addr), .rd_nib(rd_nib)
    );

    assign disp_mode = mode;

endmodule

// File: rtl/segram_ctrl_sva.sv
module segram_ctrl_sva
    import segram_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          word_vld,
    input rx_word_t      word,
    input logic [AW-1:0] cur_addr,
    input logic [1:0]    disp_mode
);

    a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
        word_vld |=> !word_vld);

    a_r4_load_folds: assert property (@(posedge clk) disable iff (rst)
        (word_vld && word.is_cmd && word.bits[7:5] == 3'b000)
        |=> int'(cur_addr) == int'($past(word.bits[AW-1:0])) % SEG_N);

    a_r5_data_steps_two: assert property (@(posedge clk) disable iff (rst)
        (word_vld && !word.is_cmd)
        |=> int'(cur_addr) == (int'($past(cur_addr)) + 2) % SEG_N);

    a_r6_nib_steps_one: assert property (@(posedge clk) disable iff (rst)
        (word_vld && word.is_cmd && word.bits[7:5] == 3'b100)
        |=> int'(cur_addr) == (int'($past(cur_addr)) + 1) % SEG_N);

    a_r8_soft_reset: assert property (@(posedge clk) disable iff (rst)
        (word_vld && word.is_cmd && word.bits[7:6] == 2'b11 && !word.bits[4])
        |=> (disp_mode == 2'd0 && cur_addr == '0));

    a_r7_mode_stable_on_data: assert property (@(posedge clk) disable iff (rst)
        (word_vld && !word.is_cmd) |=> $stable(disp_mode));

    a_r10_addr_in_range: assert property (@(posedge clk) disable iff (rst)
        int'(cur_addr) < SEG_N);

    a_r10_mode_legal: assert property (@(posedge clk) disable iff (rst)
        disp_mode != 2'b11);

endmodule

bind segram_ctrl segram_ctrl_sva u_sva (
    .clk(clk), .rst(rst), .word_vld(word_vld), .word(word),
    .cur_addr(cur_addr), .disp_mode(disp_mode)
);

// File: tb/sim_segram_ctrl.sv
`timescale 1ns/1ps
module sim_segram_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_csn = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0, ser_cd = 1'b0;
    logic [4:0] rd_addr = '0;
    logic [3:0] rd_nib;
    logic [1:0] disp_mode;

    int n_cmp = 0, n_bad = 0;
    int m_mem[18];
    int m_addr = 0, m_mode = 0;
    bit done = 0;

    always #10 clk = ~clk;

    segram_ctrl u0 (
        .clk(clk), .rst(rst), .ser_csn(ser_csn), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .ser_cd(ser_cd), .rd_addr(rd_addr),
        .rd_nib(rd_nib), .disp_mode(disp_mode)
    );

    function automatic int wrap1(int a);
        return (a + 1) % 18;
    endfunction

    task automatic model_word(input logic [7:0] b, input bit cd);
        if (!cd) begin
            m_mem[m_addr] = b[7:4];
            m_mem[wrap1(m_addr)] = b[3:0];
            m_addr = (m_addr + 2) % 18;
        end else begin
            case (b[7:5])
                3'b000: m_addr = b[4:0] % 18;
                3'b001: m_mode = 2;
                3'b010: m_mode = 0;
                3'b011: m_mode = 1;
                3'b100: begin m_mem[m_addr] = b[3:0]; m_addr = wrap1(m_addr); end
                3'b110, 3'b111: if (!b[4]) begin m_mode = 0; m_addr = 0; end
                default: ;
            endcase
        end
    endtask

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    // nbits < 8 sends a truncated word (R2); cd_flip drives the opposite cd on bits 0..6 (R3)
    task automatic send(input logic [7:0] b, input bit cd, input bit cd_flip, input int nbits);
        @(negedge clk);
        ser_csn = 1'b0;
        half();
        for (int i = 7; i > 7 - nbits; i--) begin
            ser_dat = b[i];
            ser_cd  = (i != 0 && cd_flip) ? ~cd : cd;
            half();
            ser_clk = 1'b1;
            half();
            ser_clk = 1'b0;
        end
        repeat (10) @(negedge clk);
        ser_csn = 1'b1;
        half();
        if (nbits == 8) model_word(b, cd);
    endtask

    task automatic compare(input string tag);
        @(negedge clk);
        n_cmp++;
        if (int'(disp_mode) != m_mode) begin
            n_bad++;
            $display("FAIL %s mode: got %0d expected %0d", tag, disp_mode, m_mode);
        end
        for (int a = 0; a < 21; a++) begin
            rd_addr = 5'(a);
            #1;
            n_cmp++;
            if (int'(rd_nib) != ((a < 18) ? m_mem[a] : 0)) begin
                n_bad++;
                $display("FAIL %s R10 entry %0d: got %0h expected %0h", tag, a, rd_nib,
                         (a < 18) ? m_mem[a] : 0);
            end
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        foreach (m_mem[i]) m_mem[i] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        compare("R9 reset state");

        send(8'h00, 1, 0, 8);            // R4 load 0
        send(8'hA5, 0, 0, 8);            // R5, R1 bit order
        send(8'h3C, 0, 0, 8);
        compare("R5 R1 data bytes");

        send(8'h11, 1, 0, 8);            // R4 load 17
        send(8'h96, 0, 0, 8);            // R5 wrap 17 -> 0
        send(8'h87, 0, 0, 8);            // now at 1
        compare("R5 wrap on second nibble");

        send(8'h11, 1, 0, 8);
        send(8'h8E, 1, 0, 8);            // R6 nibble at 17, pointer -> 0
        send(8'h81, 1, 0, 8);            // R6 nibble at 0
        compare("R6 nibble write and wrap");

        send(8'h19, 1, 0, 8);            // R4 25 mod 18 = 7
        send(8'h4B, 0, 0, 8);
        send(8'h1F, 1, 0, 8);            // R4 31 mod 18 = 13
        send(8'h8D, 1, 0, 8);
        compare("R4 fold out-of-range load");

        send(8'h20, 1, 0, 8); compare("R7 all lit");
        send(8'h7F, 1, 0, 8); compare("R7 from RAM");
        send(8'h5A, 1, 0, 8); compare("R7 all dark");
        send(8'h60, 1, 0, 8);

        send(8'h05, 1, 0, 8);
        send(8'hC3, 1, 0, 8);            // R8 soft reset, RAM kept
        send(8'hF1, 0, 0, 8);            // lands at 0,1
        compare("R8 soft reset");

        send(8'h60, 1, 0, 8);
        send(8'hD0, 1, 0, 8);            // R8 ignored 11x1
        send(8'hA7, 1, 0, 8);            // R8 ignored 101
        send(8'h22, 0, 0, 8);
        compare("R8 ignored opcodes");

        send(8'hFF, 0, 0, 5);            // R2 partial dropped
        send(8'h69, 0, 0, 8);
        compare("R2 partial word");

        send(8'h2D, 0, 1, 8);            // R3 cd high early, low at 8th -> data
        send(8'h8B, 1, 1, 8);            // R3 cd low early, high at 8th -> nibble
        compare("R3 qualifier at eighth edge");

        for (int k = 0; k < 20; k++) send(8'((k * 37 + 11) & 8'hFF), 0, 0, 8);
        compare("R5 long data run");

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        foreach (m_mem[i]) m_mem[i] = 0;
        m_addr = 0;
        m_mode = 0;
        compare("R9 reset clears");
        send(8'hE4, 0, 0, 8);
        compare("R9 pointer zero after reset");

        done = 1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

endmodule